// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the 16x oversampling tick for a serial receiver and transmitter from a fast reference clock. It takes a 16-bit whole-cycle divisor and a 6-bit fraction counted in sixty-fourths of a cycle. A six-bit phase accumulator adds the fraction once per tick period. Whenever that addition overflows, the period is lengthened by one reference cycle. As a result, the average spacing of the oversampling ticks equals the divisor plus the fraction over 64. For example, a divisor of 1 with a fraction of 5 gives an average spacing of about 1.078 reference cycles. A second output pulses on every sixteenth oversampling tick and marks one bit time.

Software normally computes a single 22-bit quantity: the reference clock times four, divided by the bit rate. It places the upper 16 bits on the whole divisor input and the lower 6 bits on the fraction input. A whole divisor of zero keeps the generator idle. Divisor values that change while ticks are running take effect at the next tick boundary. While the generator is disabled, they take effect at once.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, and after reset with the enable low, both `os_tick` and `baud_tick` stay low.
- R2: When `enable` is first sampled high at a clock edge with a whole divisor D of 1 or more, the first `os_tick` is high in the D-th cycle after that edge.
- R3: With enable held and divisor values D and F held, the k-th period after the first tick (k counted from 1) lasts D+1 cycles exactly when floor((k+1)·F/64) exceeds floor(k·F/64). Otherwise it lasts D cycles.
- R4: Over any 64 consecutive tick periods with D and F held, the total length is 64·D + F reference cycles.
- R5: `baud_tick` is high only together with `os_tick`. It is high on the 16th, 32nd, 48th, … oversampling tick counted from the moment the generator was last started.
- R6: A change of the divisor inputs in the middle of a period leaves that period's length unchanged. The new values set the length of the period that starts after the next tick.
- R7: If the whole divisor is 0 in a cycle where `os_tick` is high, no further tick follows. Dropping `enable` stops ticks from the next cycle onward, and it clears the accumulated fraction and the 1-in-16 count, so a restart repeats the pattern of R3 and R5 from its beginning.
- R8: The largest setting, a whole divisor of 65535 with a fraction of 63, yields a first period of 65535 cycles and a second period of 65536 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Generator run enable |
| div_int | input | 16 | Whole part of the divisor in reference cycles; 0 stops the generator |
| div_frac | input | 6 | Fractional part of the divisor in sixty-fourths |
| os_tick | output | 1 | One-cycle oversampling tick (stays high continuously for a divisor of exactly 1) |
| baud_tick | output | 1 | Every sixteenth oversampling tick |

## Verification
The hardest case to reach from the ports is the full cycle of the phase accumulator. Every one of the 64 fraction values only shows its complete pattern of stretched periods after 64 periods, because that is when the accumulator returns to its starting phase. The bench sweeps every fraction with small whole divisors and records 65 ticks for each setting. This checks each period against the floor-difference formula and the 64-period sum. Divisor changes are timed relative to an observed tick, so that they land mid-period or exactly on a boundary. The largest divisor is driven once to reach the period that needs a seventeenth bit of length.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  parameter int unsigned FBG_INT_W    = 16;
  parameter int unsigned FBG_FRAC_W   = 6;
  parameter int unsigned FBG_OS_RATIO = 16;
  parameter int unsigned FBG_SYNC_STAGES = 2;
endpackage

// File: rtl/fbg_rst_sync.sv
module fbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fbg_frac_accum.sv
module fbg_frac_accum #(
  parameter int unsigned FRAC_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry
);
  logic [FRAC_W-1:0] phase_q;
  logic [FRAC_W-1:0] phase_d;
  logic [FRAC_W:0]   sum;

  // One extra bit holds the overflow of the phase addition.
  always_comb begin
    sum   = {1'b0, phase_q} + {1'b0, frac};
    carry = sum[FRAC_W];
  end

  always_comb begin
    phase_d = phase_q;
    if (clear)     phase_d = '0;
    else if (step) phase_d = sum[FRAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/fbg_period_ctr.sv
module fbg_period_ctr #(
  parameter int unsigned INT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [INT_W-1:0] div_int,
  input  logic             stretch,
  output logic             tick,
  output logic             running,
  output logic             load,
  output logic             clear
);
  logic [INT_W-1:0] remain_q;
  logic [INT_W-1:0] remain_d;
  logic             run_q;
  logic             run_d;
  logic             at_boundary;
  logic             zero_div;

  always_comb begin
    at_boundary = !run_q || (remain_q == '0);
    zero_div    = (div_int == '0);
  end

  // Next-state: a new period length is taken only at a boundary.
  always_comb begin
    run_d    = run_q;
    remain_d = remain_q;
    load     = 1'b0;
    clear    = 1'b0;
    if (!enable) begin
      run_d    = 1'b0;
      remain_d = '0;
      clear    = 1'b1;
    end else if (at_boundary) begin
      if (zero_div) begin
        run_d    = 1'b0;
        remain_d = '0;
        clear    = 1'b1;
      end else begin
        run_d    = 1'b1;
        load     = 1'b1;
        // length D+stretch, stored as remaining cycles minus one
        remain_d = div_int - INT_W'(!stretch);
      end
    end else begin
      remain_d = remain_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      remain_q <= '0;
    end else begin
      run_q    <= run_d;
      remain_q <= remain_d;
    end
  end

  assign tick    = run_q && (remain_q == '0);
  assign running = run_q;
endmodule

// File: rtl/fbg_subdiv.sv
module fbg_subdiv #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic tick_in,
  output logic tick_out
);
  localparam int unsigned CW = (RATIO > 1) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = cnt_q;
    if (clear)        cnt_d = '0;
    else if (tick_in) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_out = tick_in && wrap;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
#(
  parameter int unsigned INT_W    = FBG_INT_W,
  parameter int unsigned FRAC_W   = FBG_FRAC_W,
  parameter int unsigned OS_RATIO = FBG_OS_RATIO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic              os_tick,
  output logic              baud_tick
);
  logic rst_core_n;
  logic stretch;
  logic running;
  logic load;
  logic clear;

  fbg_rst_sync #(.STAGES(FBG_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  fbg_frac_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_core_n),
    .clear (clear),
    .step  (load),
    .frac  (div_frac),
    .carry (stretch)
  );

  fbg_period_ctr #(.INT_W(INT_W)) u_period (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .enable  (enable),
    .div_int (div_int),
    .stretch (stretch),
    .tick    (os_tick),
    .running (running),
    .load    (load),
    .clear   (clear)
  );

  fbg_subdiv #(.RATIO(OS_RATIO)) u_subdiv (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clear    (!running),
    .tick_in  (os_tick),
    .tick_out (baud_tick)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
  parameter int unsigned INT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic [INT_W-1:0] div_int,
  input logic             os_tick,
  input logic             baud_tick
);
  logic [INT_W+1:0] gap_q;
  logic [INT_W+1:0] exp_len_q;
  logic             armed_q;

  // Cycles since the last tick, and the whole divisor seen at that tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      exp_len_q <= '0;
      armed_q   <= 1'b0;
    end else if (!enable) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (os_tick) begin
      armed_q   <= (div_int != '0);
      exp_len_q <= {2'b00, div_int};
      gap_q     <= 1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) assert_reset_quiet_R1: assert (!os_tick && !baud_tick);
  end

  assert_period_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && armed_q) |-> (gap_q == exp_len_q || gap_q == exp_len_q + 1'b1));

  assert_baud_with_os_R5: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> os_tick);

  assert_stop_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (os_tick && enable && div_int == '0) |=> !os_tick);

  assert_stop_on_disable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !os_tick);
endmodule

bind frac_baud_gen fbg_checker #(.INT_W(INT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .div_int   (div_int),
  .os_tick   (os_tick),
  .baud_tick (baud_tick)
);

// File: tb/frac_baud_gen_tb.sv
`timescale 1ns/1ps
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable;
  logic [15:0] div_int;
  logic [5:0]  div_frac;
  logic        os_tick;
  logic        baud_tick;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .div_int(div_int), .div_frac(div_frac),
    .os_tick(os_tick), .baud_tick(baud_tick)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
        finish_run();
      end
    end
  end

  // Count negedges until the next os_tick; returns cycles waited.
  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!os_tick);
  endtask

  task automatic run_cfg(input int d, input int f, input int nt, input bit do_sum);
    int times[0:69];
    int got = 0;
    int t = 0;
    int bad = 0;
    int bad_b = 0;
    int b_act = 0;
    int b_exp = 0;
    int p_act = 0;
    int p_exp = 0;
    enable = 1'b0;
    @(negedge clk);
    div_int  = 16'(d);
    div_frac = 6'(f);
    @(negedge clk);
    enable = 1'b1;
    while (got < nt) begin
      @(negedge clk);
      t++;
      if (baud_tick && !os_tick) bad_b++;
      if (os_tick) begin
        got++;
        times[got] = t;
        if (baud_tick != (got % 16 == 0)) begin
          bad_b++;
          b_act = got;
          b_exp = 16;
        end
      end
    end
    // R2: first tick latency
    check(times[1] == d, "R2", $sformatf("first tick d=%0d f=%0d", d, f), times[1], d);
    for (int k = 1; k < nt; k++) begin
      int len = times[k+1] - times[k];
      int ex  = d + ((((k + 1) * f) / 64 > (k * f) / 64) ? 1 : 0);
      if (len != ex) begin
        bad++;
        p_act = len;
        p_exp = ex;
      end
    end
    // R3: per-period stretch pattern
    check(bad == 0, "R3", $sformatf("period d=%0d f=%0d", d, f), p_act, p_exp);
    if (do_sum)  // R4: 64-period total
      check(times[65] - times[1] == 64 * d + f, "R4",
            $sformatf("sum64 d=%0d f=%0d", d, f), times[65] - times[1], 64 * d + f);
    // R5: one-in-sixteen baud tick
    check(bad_b == 0, "R5", $sformatf("baud d=%0d f=%0d", d, f), b_act, b_exp);
    if (nt == 2 && d == 65535 && f == 63)  // R8: widest period
      check(times[2] - times[1] == 65536, "R8", "second max period",
            times[2] - times[1], 65536);
  endtask

  initial begin
    int n;
    int seen;
    rst_n    = 1'b0;
    enable   = 1'b0;
    div_int  = 16'd3;
    div_frac = 6'd0;
    repeat (3) @(negedge clk);
    check(!os_tick && !baud_tick, "R1", "outputs in reset", {os_tick, baud_tick}, 0);
    rst_n = 1'b1;
    seen = 0;
    repeat (20) begin
      @(negedge clk);
      if (os_tick || baud_tick) seen++;
    end
    check(seen == 0, "R1", "idle after reset", seen, 0);

    // R3 R4 R5 R2: full fraction sweep with small whole divisors
    for (int d = 1; d <= 2; d++)
      for (int f = 0; f < 64; f++)
        run_cfg(d, f, 65, 1'b1);

    // R6: mid-period change applies after the next tick
    run_cfg(4, 0, 1, 1'b0);
    @(negedge clk);
    div_int = 16'd7;
    wait_tick(n);
    check(n == 3, "R6", "period in flight kept", n, 3);
    wait_tick(n);
    check(n == 7, "R6", "new divisor next period", n, 7);

    // R7: zero divisor at a tick boundary stops the generator
    div_int = 16'd0;
    seen = 0;
    repeat (100) begin
      @(negedge clk);
      if (os_tick || baud_tick) seen++;
    end
    check(seen == 0, "R7", "no tick after zero divisor", seen, 0);

    // R7: dropping enable mid-period stops at once and clears state
    run_cfg(3, 0, 1, 1'b0);
    @(negedge clk);
    enable = 1'b0;
    seen = 0;
    repeat (50) begin
      @(negedge clk);
      if (os_tick) seen++;
    end
    check(seen == 0, "R7", "no tick while disabled", seen, 0);
    enable = 1'b1;
    wait_tick(n);
    check(n == 3, "R7", "restart latency", n, 3);
    // R7: partial run then disable, then full pattern must restart from phase 0
    run_cfg(1, 37, 7, 1'b0);
    run_cfg(1, 37, 65, 1'b1);

    // R8: widest setting
    run_cfg(65535, 63, 2, 1'b0);

    enable = 1'b0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule